// File: doc/BRIEF.md
# Contrast PWM Generator

This block produces a pulse-width-modulated drive signal for a display's contrast or backlight input. Software programs a control register and a duty register through a small write port. The control register enables the output, picks the output polarity and selects a clock prescaler. The prescaler divides the input clock by 1, 2, 4 or 8. Each prescaled tick advances an 8-bit period counter. That counter is compared with a shadow copy of the duty value to form the output level.

The duty value is copied into the shadow only at the counter wrap, or while the block is disabled. A write in mid-period therefore never shortens or stretches the pulse that is already in progress. While disabled, the output rests at the inactive level of the chosen polarity, and the counter and prescaler are held cleared. Each new enable therefore starts a period from count zero.

Top module: `contrast_pwm`

## Requirements
- R1: After reset the duty register is 0xC8 and the control register is 0x0. The block is therefore disabled with negative polarity, and pwm_out is 1.
- R2: A cycle with wr_en high writes wr_data into the control register when wr_sel is 0, and into the duty register when wr_sel is 1. The control fields are: bit 0 enable, bit 1 polarity (1 = positive), bits 3:2 prescaler select.
- R3: The prescaler select values 0, 1, 2 and 3 advance the period counter once every 1, 2, 4 and 8 input clocks.
- R4: The period counter is 8 bits wide and wraps from 255 to 0, so one output period spans 256 counter steps.
- R5: With positive polarity and the block enabled, pwm_out is 1 while the counter is below the shadow duty value and 0 otherwise. It is registered, so it follows the counter one clock later.
- R6: With negative polarity, pwm_out is the complement of the positive-polarity output.
- R7: A duty value of 0 gives a constant inactive level. A duty value of 255 gives an active level for 255 of every 256 counter steps.
- R8: While disabled, pwm_out is 0 for positive polarity and 1 for negative polarity, and the counter is held at 0. The duty value in force at enable is the one used in the first period.
- R9: A duty write while enabled takes effect only when the counter wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 duty |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The checker asserts on every cycle the invariants that one clock fully determines. While disabled, the output takes the inactive level and the counter is cleared. The counter moves only on a prescaler tick. The shadow duty changes only at a wrap. A zero duty forces the inactive level. A prescaler tick never repeats on the next clock when the divide is above one. The exact duty ratio at each prescale setting and polarity depends on a whole period of history, as does the deferral of a mid-period duty write to the next wrap. Only the bench's cycle-accurate scoreboard and its counts of high samples over full periods can show these.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // control register field positions
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_POL_BIT = 1;
   localparam int CTRL_SEL_LSB = 2;

   typedef enum logic {
      REG_CTRL = 1'b0,
      REG_DUTY = 1'b1
   } pwm_reg_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int                 CNT_W    = 8,
   parameter int                 SEL_W    = 2,
   parameter logic [CNT_W-1:0]   DUTY_RST = 8'hC8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [CNT_W-1:0]   wr_data,
   output logic               en,
   output logic               pol,
   output logic [SEL_W-1:0]   sel,
   output logic [CNT_W-1:0]   duty
);
   localparam int CTRL_W = CTRL_SEL_LSB + SEL_W;

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  duty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         duty_q <= DUTY_RST;
      end else if (wr_en) begin
         if (pwm_reg_e'(wr_sel) == REG_CTRL)
            ctrl_q <= wr_data[CTRL_W-1:0];
         else
            duty_q <= wr_data;
      end
   end

   assign en   = ctrl_q[CTRL_EN_BIT];
   assign pol  = ctrl_q[CTRL_POL_BIT];
   assign sel  = ctrl_q[CTRL_SEL_LSB +: SEL_W];
   assign duty = duty_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   // mask bit i is set when the selected divide needs counter bit i
   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (int'(sel) > i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (!en) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   assign tick = en && (&(pre_q | ~mask));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] duty,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp
);
   logic wrap;
   assign wrap = tick && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         cmp <= '0;
      end else if (!en) begin
         cnt <= '0;
         cmp <= duty;
      end else begin
         if (tick) cnt <= cnt + 1'b1;
         if (wrap) cmp <= duty;
      end
   end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pol,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output logic             pwm_out
);
   logic active;
   logic level_d;

   assign active  = en && (cnt < cmp);
   assign level_d = active ? pol : !pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_out <= 1'b1;
      else        pwm_out <= level_d;
   end
endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm #(
   parameter int               CNT_W    = 8,
   parameter int               SEL_W    = 2,
   parameter logic [CNT_W-1:0] DUTY_RST = 8'hC8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("contrast_pwm: CNT_W out of range");
   end
   if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
      $error("contrast_pwm: SEL_W out of range");
   end
   if (pwm_pkg::CTRL_SEL_LSB + SEL_W > CNT_W) begin : g_bad_fit
      $error("contrast_pwm: control fields do not fit the write data");
   end

   logic             en_w;
   logic             pol_w;
   logic [SEL_W-1:0] sel_w;
   logic [CNT_W-1:0] duty_w;
   logic             tick_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] cmp_w;

   pwm_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DUTY_RST(DUTY_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .en(en_w), .pol(pol_w), .sel(sel_w), .duty(duty_w)
   );

   pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(en_w), .sel(sel_w), .tick(tick_w)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .duty(duty_w),
      .cnt(cnt_w), .cmp(cmp_w)
   );

   pwm_outstage #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .en(en_w), .pol(pol_w), .cnt(cnt_w),
      .cmp(cmp_w), .pwm_out(pwm_out)
   );
endmodule

// File: rtl/contrast_pwm_checker.sv
module contrast_pwm_checker #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pol,
   input logic [SEL_W-1:0] sel,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp,
   input logic             pwm_out
);
   // R8: disabled output rests at the inactive level
   assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pwm_out == !$past(pol)));

   // R8: counter cleared while disabled
   assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

   // R3: counter moves only on a prescaler tick
   assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt));

   // R3: with a divide above one, ticks never fall on adjacent clocks
   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel != '0) |=> (!tick || sel != $past(sel)));

   // R9: shadow duty changes only at the wrap
   assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !(tick && (&cnt))) |=> $stable(cmp));

   // R7: zero duty yields the inactive level
   assert_zero_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmp == '0) |=> (pwm_out == !$past(pol)));
endmodule

bind contrast_pwm contrast_pwm_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_w), .pol(pol_w), .sel(sel_w),
   .tick(tick_w), .cnt(cnt_w), .cmp(cmp_w), .pwm_out(pwm_out)
);

// File: tb/contrast_pwm_bench.sv
`timescale 1ns/1ps
module contrast_pwm_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       pwm_out;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   contrast_pwm u_contrast_pwm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   // ---------------- reference model (from the requirements) ----------------
   logic [3:0] m_ctrl;
   logic [7:0] m_duty, m_cnt, m_cmp;
   logic [2:0] m_pre;
   bit         exp_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 4'h0; m_duty = 8'hC8; m_cnt = 0; m_cmp = 0; m_pre = 0;
         exp_q.delete();
      end else begin
         bit en, pol, tk, lvl;
         logic [2:0] mask;
         en   = m_ctrl[0];
         pol  = m_ctrl[1];
         mask = 3'((1 << m_ctrl[3:2]) - 1);
         lvl  = (en && (m_cnt < m_cmp)) ? pol : !pol;
         exp_q.push_back(lvl);
         tk   = en && ((m_pre & mask) == mask);
         if (!en) begin
            m_cnt = 0; m_cmp = m_duty; m_pre = 0;
         end else begin
            if (tk && m_cnt == 8'hFF) m_cmp = m_duty;
            if (tk) m_cnt = m_cnt + 1;
            m_pre = m_pre + 1;
         end
         if (wr_en) begin
            if (wr_sel) m_duty = wr_data;
            else        m_ctrl = wr_data[3:0];
         end
      end
   end

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         n_vec++;
         if (pwm_out !== e) begin
            n_bad++;
            $display("FAIL %s scoreboard: pwm_out=%0b expected %0b at %0t",
                     cur_req, pwm_out, e, $time);
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic write_reg(input bit sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_high(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         #0.5;
         if (pwm_out) hi++;
      end
   endtask

   task automatic check_eq(input string req, input int act, input int exp_v);
      n_vec++;
      if (act != exp_v) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int hi;
      idle(5);
      rst_n = 1'b1;
      idle(2);
      cur_req = "R1";
      check_eq("R1 reset level", int'(pwm_out), 1);
      count_high(20, hi);
      check_eq("R1 idle while disabled", hi, 20);

      // enable, positive, divide 1, default duty 0xC8 (R2 control write)
      cur_req = "R5";
      write_reg(1'b0, 8'h03);
      idle(10);
      count_high(256, hi);
      check_eq("R1 default duty ratio", hi, 200);
      count_high(512, hi);
      check_eq("R4 two full periods", hi, 400);

      cur_req = "R6";
      write_reg(1'b0, 8'h01);
      idle(5);
      count_high(256, hi);
      check_eq("R6 negative polarity", hi, 56);

      cur_req = "R7";
      write_reg(1'b0, 8'h03);
      write_reg(1'b1, 8'h00);
      idle(300);
      count_high(256, hi);
      check_eq("R7 zero duty", hi, 0);
      write_reg(1'b1, 8'hFF);
      idle(300);
      count_high(256, hi);
      check_eq("R7 full duty", hi, 255);

      cur_req = "R3";
      write_reg(1'b1, 8'h40);
      write_reg(1'b0, 8'h0F);
      idle(2100);
      count_high(2048, hi);
      check_eq("R3 divide by 8", hi, 512);
      write_reg(1'b0, 8'h0B);
      idle(1030);
      count_high(1024, hi);
      check_eq("R3 divide by 4", hi, 256);
      write_reg(1'b0, 8'h07);
      idle(520);
      count_high(512, hi);
      check_eq("R3 divide by 2", hi, 128);

      // R9: mid-period duty writes; scoreboard checks deferral cycle by cycle
      cur_req = "R9";
      write_reg(1'b0, 8'h03);
      write_reg(1'b1, 8'h80);
      idle(300);
      idle(77);
      write_reg(1'b1, 8'h10);
      idle(130);
      write_reg(1'b1, 8'hE0);
      idle(600);
      count_high(256, hi);
      check_eq("R9 new duty after wrap", hi, 224);

      cur_req = "R8";
      write_reg(1'b0, 8'h02);
      count_high(50, hi);
      check_eq("R8 disabled positive", hi, 0);
      write_reg(1'b0, 8'h00);
      count_high(50, hi);
      check_eq("R8 disabled negative", hi, 50);
      write_reg(1'b1, 8'h20);
      write_reg(1'b0, 8'h03);
      idle(3);
      count_high(256, hi);
      check_eq("R8 duty adopted at enable", hi, 32);

      idle(5);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule